// File: doc/BRIEF.md
# Class-Separated Network Receive Buffer

This block sits on the receive side of a node's network interface. Every arriving packet carries a source node number, a class bit (request or response) and a payload. The two classes are kept in separate queues whose space is set aside ahead of time. Because of this separation, a backlog of requests can never stop responses from draining into the node. The node therefore keeps absorbing traffic even while its own outbound path is stalled.

Request space is divided among the remote nodes. Each remote source may hold at most `REQ_LIMIT` requests in this node at any time. A request that arrives while its source is already at that limit is not stored. Instead, its source number is placed on a small outbound queue of negative acknowledgements (NACKs), so the sender can retry later. A source's slot is released when the local handler pops one of that source's requests. Packets whose source number is this node's own number, or lies outside the node range, are malformed: they are accepted and discarded.

Top module: `nic_rx_classq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, `req_valid`, `rsp_valid` and `nack_valid` are low. Reset also clears every per-source request count.
- R2: A request (`in_cls` = 0) from a valid remote source with a free slot is accepted. It appears on the request output in the cycle after the handshake, with its source and payload. Requests leave in arrival order, and each output is held stable while `req_ready` is low.
- R3: A response (`in_cls` = 1) is accepted whenever the response queue has a free entry, whatever the state of the request queue or the NACK queue. Responses leave in arrival order and are held stable while `rsp_ready` is low.
- R4: A request from a source that already holds `REQ_LIMIT` requests is not stored. The cycle after the handshake, its source number appears on `nack_dst` with `nack_valid` high.
- R5: One source reaching its limit does not affect whether requests from other sources are accepted.
- R6: Popping a request releases one slot of that request's source. An accepted request and a popped request of the same source in the same cycle leave that source's count unchanged. No count ever exceeds `REQ_LIMIT`.
- R7: While the NACK queue is full, `in_ready` is low for requests from valid sources and stays driven for responses.
- R8: A packet whose source equals `NODE_ID`, or is not below `NODES`, sees `in_ready` high and produces nothing on any output.
- R9: While the response queue holds `REQ_LIMIT` entries, `in_ready` is low for responses.
- R10: The request queue holds `REQ_LIMIT`·(`NODES`-1) entries, so every remote source can fill its share at once with no NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Incoming packet present |
| in_ready | output | 1 | Incoming packet taken this cycle if valid |
| in_src | input | SRC_W | Source node number of incoming packet |
| in_cls | input | 1 | Class: 0 request, 1 response |
| in_data | input | PAY_W | Incoming payload |
| req_valid | output | 1 | Request available to handler |
| req_ready | input | 1 | Handler pops request |
| req_src | output | SRC_W | Source of head request |
| req_data | output | PAY_W | Payload of head request |
| rsp_valid | output | 1 | Response available to handler |
| rsp_ready | input | 1 | Handler pops response |
| rsp_src | output | SRC_W | Source of head response |
| rsp_data | output | PAY_W | Payload of head response |
| nack_valid | output | 1 | NACK ready to send |
| nack_ready | input | 1 | NACK taken by network |
| nack_dst | output | SRC_W | Node to receive the NACK |

## Verification
The bench fills one source to its limit and checks that a further request from it turns into a NACK while another source is still admitted. A design that shared the bound across sources would refuse the second source. It also checks the cycle where a request from a source is accepted while one of that source's requests is popped. If the count got this wrong it would drift, and a later request would be wrongly NACKed or wrongly stored. With the NACK queue full, the bench checks that requests stall while responses still enter, which catches any coupling of the two classes. It also sends a packet carrying the node's own number and expects it never to reach any output, and it checks that all remote shares can be full at the same time.

// File: rtl/nic_rx_pkg.sv
// Shared types for the class-separated receive buffer.
// Assumes a one-bit class field: 0 request, 1 response.
package nic_rx_pkg;
    typedef enum logic {
        CLS_REQ = 1'b0,
        CLS_RSP = 1'b1
    } pkt_cls_e;
endpackage

// File: rtl/nic_rx_fifo.sv
// Synchronous FIFO with combinational head read.
// Assumes the caller never pushes when full nor pops when empty.
module nic_rx_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;

    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));
    assign head_data = mem[rd_ptr];

    // Store pushed words.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/nic_rx_credits.sv
// Per-source counters of request slots in use.
// Assumes inc only when has_room is high and dec only for a held request.
module nic_rx_credits #(
    parameter int NODES = 4,
    parameter int LIMIT = 2,
    parameter int SRC_W = 2,
    parameter int CW    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic [SRC_W-1:0]   inc_src,
    input  logic               dec,
    input  logic [SRC_W-1:0]   dec_src,
    output logic               has_room,
    output logic [NODES*CW-1:0] lvl_flat
);
    logic [CW-1:0] lvl [NODES];
    logic [CW-1:0] sel_lvl;

    for (genvar g = 0; g < NODES; g++) begin : g_src
        logic hit_inc, hit_dec;
        assign hit_inc = inc && (inc_src == SRC_W'(g));
        assign hit_dec = dec && (dec_src == SRC_W'(g));

        // Track slots held by source g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lvl[g] <= '0;
            end else begin
                case ({hit_inc, hit_dec})
                    2'b10:   lvl[g] <= lvl[g] + 1'b1;
                    2'b01:   lvl[g] <= lvl[g] - 1'b1;
                    default: lvl[g] <= lvl[g];
                endcase
            end
        end

        assign lvl_flat[g*CW +: CW] = lvl[g];
    end

    // Select the level of the arriving source.
    always_comb begin
        sel_lvl = '0;
        for (int i = 0; i < NODES; i++) begin
            if (inc_src == SRC_W'(i)) sel_lvl = lvl[i];
        end
    end

    assign has_room = (sel_lvl < CW'(LIMIT));
endmodule

// File: rtl/nic_rx_classq.sv
// Receive buffer that splits traffic into request and response queues.
// Requests are bounded per source; overflow turns into a NACK.
// Assumes in_cls 0 = request, 1 = response; malformed sources are dropped.
module nic_rx_classq #(
    parameter int NODES      = 4,
    parameter int NODE_ID    = 0,
    parameter int REQ_LIMIT  = 2,
    parameter int PAY_W      = 8,
    parameter int NACK_DEPTH = 2,
    localparam int SRC_W     = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SRC_W-1:0] in_src,
    input  logic             in_cls,
    input  logic [PAY_W-1:0] in_data,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [SRC_W-1:0] req_src,
    output logic [PAY_W-1:0] req_data,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [SRC_W-1:0] rsp_src,
    output logic [PAY_W-1:0] rsp_data,
    output logic             nack_valid,
    input  logic             nack_ready,
    output logic [SRC_W-1:0] nack_dst
);
    import nic_rx_pkg::*;

    localparam int REQ_DEPTH = REQ_LIMIT * (NODES - 1);
    localparam int RSP_DEPTH = REQ_LIMIT;
    localparam int CRD_W     = $clog2(REQ_LIMIT + 1);
    localparam int ENT_W     = SRC_W + PAY_W;

    pkt_cls_e   cls;
    logic       malformed, fire, has_room;
    logic       req_take, rsp_take, nack_push;
    logic       req_pop, rsp_pop, nack_pop;
    logic       req_empty, req_full, rsp_empty, rsp_full, nack_empty, nack_full;
    logic [ENT_W-1:0] req_head, rsp_head;
    logic [NODES*CRD_W-1:0] lvl_flat;

    assign cls = pkt_cls_e'(in_cls);

    // Classify source validity and decide acceptance.
    always_comb begin
        malformed = (in_src == SRC_W'(NODE_ID)) ||
                    ({1'b0, in_src} >= (SRC_W + 1)'(NODES));
        if (malformed)            in_ready = 1'b1;
        else if (cls == CLS_RSP)  in_ready = !rsp_full;
        else                      in_ready = !nack_full;
        fire      = in_valid && in_ready;
        req_take  = fire && !malformed && (cls == CLS_REQ) && has_room;
        nack_push = fire && !malformed && (cls == CLS_REQ) && !has_room;
        rsp_take  = fire && !malformed && (cls == CLS_RSP);
    end

    assign req_pop  = req_valid && req_ready;
    assign rsp_pop  = rsp_valid && rsp_ready;
    assign nack_pop = nack_valid && nack_ready;

    nic_rx_credits #(
        .NODES(NODES), .LIMIT(REQ_LIMIT), .SRC_W(SRC_W), .CW(CRD_W)
    ) u_credits (
        .clk(clk), .rst_n(rst_n),
        .inc(req_take), .inc_src(in_src),
        .dec(req_pop), .dec_src(req_src),
        .has_room(has_room), .lvl_flat(lvl_flat)
    );

    nic_rx_fifo #(.WIDTH(ENT_W), .DEPTH(REQ_DEPTH)) u_reqq (
        .clk(clk), .rst_n(rst_n),
        .push(req_take), .push_data({in_src, in_data}),
        .pop(req_pop), .head_data(req_head),
        .empty(req_empty), .full(req_full)
    );

    nic_rx_fifo #(.WIDTH(ENT_W), .DEPTH(RSP_DEPTH)) u_rspq (
        .clk(clk), .rst_n(rst_n),
        .push(rsp_take), .push_data({in_src, in_data}),
        .pop(rsp_pop), .head_data(rsp_head),
        .empty(rsp_empty), .full(rsp_full)
    );

    nic_rx_fifo #(.WIDTH(SRC_W), .DEPTH(NACK_DEPTH)) u_nackq (
        .clk(clk), .rst_n(rst_n),
        .push(nack_push), .push_data(in_src),
        .pop(nack_pop), .head_data(nack_dst),
        .empty(nack_empty), .full(nack_full)
    );

    assign req_valid  = !req_empty;
    assign rsp_valid  = !rsp_empty;
    assign nack_valid = !nack_empty;
    assign {req_src, req_data} = req_head;
    assign {rsp_src, rsp_data} = rsp_head;
endmodule

// File: rtl/nic_rx_classq_chk.sv
// Protocol and capacity checks for the class-separated receive buffer.
module nic_rx_classq_chk #(
    parameter int NODES     = 4,
    parameter int NODE_ID   = 0,
    parameter int REQ_LIMIT = 2,
    parameter int PAY_W     = 8,
    parameter int SRC_W     = 2,
    parameter int CRD_W     = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_cls,
    input logic [SRC_W-1:0] in_src,
    input logic             req_valid,
    input logic             req_ready,
    input logic [SRC_W-1:0] req_src,
    input logic [PAY_W-1:0] req_data,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PAY_W-1:0] rsp_data,
    input logic             nack_valid,
    input logic             nack_ready,
    input logic [SRC_W-1:0] nack_dst,
    input logic             req_take,
    input logic             req_full,
    input logic [NODES*CRD_W-1:0] lvl_flat
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!req_valid && !rsp_valid && !nack_valid));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_data) && $stable(req_src)));

    // R3
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R4
    nack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_valid && !nack_ready) |=> (nack_valid && $stable(nack_dst)));

    // R7
    req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_cls && (in_src != SRC_W'(NODE_ID)) && !in_ready) |-> nack_valid);

    // R8
    malformed_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_src == SRC_W'(NODE_ID)) |-> in_ready);

    // R9
    rsp_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_cls && !in_ready) |-> rsp_valid);

    // R10
    req_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_take |-> !req_full);

    for (genvar g = 0; g < NODES; g++) begin : g_bound
        // R6
        credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_flat[g*CRD_W +: CRD_W] <= CRD_W'(REQ_LIMIT));
    end
endmodule

bind nic_rx_classq nic_rx_classq_chk #(
    .NODES(NODES), .NODE_ID(NODE_ID), .REQ_LIMIT(REQ_LIMIT),
    .PAY_W(PAY_W), .SRC_W(SRC_W), .CRD_W(CRD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls), .in_src(in_src),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .nack_valid(nack_valid), .nack_ready(nack_ready), .nack_dst(nack_dst),
    .req_take(req_take), .req_full(req_full), .lvl_flat(lvl_flat)
);

// File: tb/nic_rx_classq_bench.sv
`timescale 1ns/1ps
module nic_rx_classq_bench;
    localparam int NODES = 4;
    localparam int PAY_W = 8;
    localparam int SRC_W = 2;
    localparam int NV    = 36;

    typedef struct packed {
        logic       v;  logic c;  logic [1:0] s;  logic [7:0] d;
        logic       rr; logic sr; logic nr;
        logic       ir;
        logic       qv; logic [1:0] qs; logic [7:0] qd;
        logic       pv; logic [7:0] pd;
        logic       nv; logic [1:0] ns;
        logic [3:0] rq;
    } vec_t;

    // Fields: v c s d | rr sr nr | ir | qv qs qd | pv pd | nv ns | requirement
    localparam vec_t VT [NV] = '{
        '{0,0,1, 0, 0,0,0, 1, 0,0, 0, 0, 0, 0,0, 2},  // R2 idle
        '{1,0,1,11, 0,0,0, 1, 0,0, 0, 0, 0, 0,0, 2},  // R2
        '{1,0,1,12, 0,0,0, 1, 1,1,11, 0, 0, 0,0, 2},  // R2
        '{1,0,1,13, 0,0,0, 1, 1,1,11, 0, 0, 0,0, 4},  // R4 source 1 full
        '{1,0,2,21, 0,0,0, 1, 1,1,11, 0, 0, 1,1, 5},  // R5 source 2 admitted
        '{1,1,3,31, 0,0,0, 1, 1,1,11, 0, 0, 1,1, 3},  // R3
        '{1,0,1,14, 0,0,0, 1, 1,1,11, 1,31, 1,1, 4},  // R4 second NACK
        '{1,0,2,22, 0,0,0, 0, 1,1,11, 1,31, 1,1, 7},  // R7 NACK queue full
        '{1,1,2,32, 0,0,0, 1, 1,1,11, 1,31, 1,1, 3},  // R3 response still taken
        '{1,1,3,33, 0,0,0, 0, 1,1,11, 1,31, 1,1, 9},  // R9 response queue full
        '{1,0,0,99, 0,0,0, 1, 1,1,11, 1,31, 1,1, 8},  // R8 own id
        '{0,0,1, 0, 0,0,1, 0, 1,1,11, 1,31, 1,1, 7},  // R7
        '{0,0,1, 0, 0,0,1, 1, 1,1,11, 1,31, 1,1, 4},  // R4
        '{0,0,1, 0, 1,0,0, 1, 1,1,11, 1,31, 0,0, 6},  // R6 pop frees slot
        '{1,0,1,15, 1,0,0, 1, 1,1,12, 1,31, 0,0, 6},  // R6 accept+pop same source
        '{1,0,1,16, 0,0,0, 1, 1,2,21, 1,31, 0,0, 6},  // R6
        '{1,0,1,17, 0,0,0, 1, 1,2,21, 1,31, 0,0, 6},  // R6 now at limit
        '{0,0,1, 0, 0,1,1, 1, 1,2,21, 1,31, 1,1, 3},  // R3
        '{0,0,1, 0, 1,1,0, 1, 1,2,21, 1,32, 0,0, 2},  // R2
        '{0,0,1, 0, 1,0,0, 1, 1,1,15, 0, 0, 0,0, 2},  // R2
        '{0,0,1, 0, 1,0,0, 1, 1,1,16, 0, 0, 0,0, 8},  // R8 nothing of own id
        '{0,0,1, 0, 0,0,0, 1, 0,0, 0, 0, 0, 0,0, 8},  // R8
        '{1,0,1,41, 0,0,0, 1, 0,0, 0, 0, 0, 0,0,10},  // R10
        '{1,0,1,42, 0,0,0, 1, 1,1,41, 0, 0, 0,0,10},  // R10
        '{1,0,2,43, 0,0,0, 1, 1,1,41, 0, 0, 0,0,10},  // R10
        '{1,0,2,44, 0,0,0, 1, 1,1,41, 0, 0, 0,0,10},  // R10
        '{1,0,3,45, 0,0,0, 1, 1,1,41, 0, 0, 0,0,10},  // R10
        '{1,0,3,46, 0,0,0, 1, 1,1,41, 0, 0, 0,0,10},  // R10
        '{0,0,1, 0, 0,0,0, 1, 1,1,41, 0, 0, 0,0,10},  // R10 no NACK
        '{0,0,1, 0, 1,0,0, 1, 1,1,41, 0, 0, 0,0,10},  // R10
        '{0,0,1, 0, 1,0,0, 1, 1,1,42, 0, 0, 0,0,10},  // R10
        '{0,0,1, 0, 1,0,0, 1, 1,2,43, 0, 0, 0,0,10},  // R10
        '{0,0,1, 0, 1,0,0, 1, 1,2,44, 0, 0, 0,0,10},  // R10
        '{0,0,1, 0, 1,0,0, 1, 1,3,45, 0, 0, 0,0,10},  // R10
        '{0,0,1, 0, 1,0,0, 1, 1,3,46, 0, 0, 0,0,10},  // R10
        '{0,0,1, 0, 0,0,0, 1, 0,0, 0, 0, 0, 0,0, 2}   // R2 drained
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0, in_cls = 1'b0;
    logic [SRC_W-1:0] in_src = '0;
    logic [PAY_W-1:0] in_data = '0;
    logic             req_ready = 1'b0, rsp_ready = 1'b0, nack_ready = 1'b0;
    logic             in_ready, req_valid, rsp_valid, nack_valid;
    logic [SRC_W-1:0] req_src, rsp_src, nack_dst;
    logic [PAY_W-1:0] req_data, rsp_data;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    nic_rx_classq #(
        .NODES(NODES), .NODE_ID(0), .REQ_LIMIT(2), .PAY_W(PAY_W), .NACK_DEPTH(2)
    ) u_nic_rx_classq (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
        .in_cls(in_cls), .in_data(in_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_src(rsp_src), .rsp_data(rsp_data),
        .nack_valid(nack_valid), .nack_ready(nack_ready), .nack_dst(nack_dst)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic c, input logic [1:0] s, input logic [7:0] d);
        in_valid = v; in_cls = c; in_src = s; in_data = d;
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        #1;
        check("R1 outputs idle in reset", {29'd0, req_valid, rsp_valid, nack_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            logic ok;
            @(negedge clk);
            drive(VT[i].v, VT[i].c, VT[i].s, VT[i].d);
            req_ready = VT[i].rr; rsp_ready = VT[i].sr; nack_ready = VT[i].nr;
            #1;
            ok = (in_ready === VT[i].ir) && (req_valid === VT[i].qv) &&
                 (rsp_valid === VT[i].pv) && (nack_valid === VT[i].nv);
            if (VT[i].qv) ok = ok && (req_src === VT[i].qs) && (req_data === VT[i].qd);
            if (VT[i].pv) ok = ok && (rsp_data === VT[i].pd);
            if (VT[i].nv) ok = ok && (nack_dst === VT[i].ns);
            n_checks++;
            if (!ok) begin
                n_fail++;
                $display("FAIL R%0d step %0d actual ir=%b qv=%b qs=%0d qd=%0d pv=%b pd=%0d nv=%b ns=%0d expected ir=%b qv=%b qs=%0d qd=%0d pv=%b pd=%0d nv=%b ns=%0d",
                         VT[i].rq, i, in_ready, req_valid, req_src, req_data, rsp_valid, rsp_data,
                         nack_valid, nack_dst, VT[i].ir, VT[i].qv, VT[i].qs, VT[i].qd,
                         VT[i].pv, VT[i].pd, VT[i].nv, VT[i].ns);
            end
        end

        // R1: reset mid-traffic clears queues and source counts
        @(negedge clk); drive(1, 0, 1, 8'd51); req_ready = 0; rsp_ready = 0; nack_ready = 0;
        @(negedge clk); drive(1, 0, 1, 8'd52);
        @(negedge clk); drive(1, 1, 2, 8'd53);
        @(negedge clk); drive(0, 0, 1, 8'd0); rst_n = 1'b0;
        @(negedge clk); #1;
        check("R1 outputs idle after reset", {29'd0, req_valid, rsp_valid, nack_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); drive(1, 0, 1, 8'd54); #1;
        check("R1 ready after reset", {31'd0, in_ready}, 32'd1);
        @(negedge clk); drive(1, 0, 1, 8'd55); #1;
        check("R1 first request after reset", {23'd0, req_valid, req_data}, {23'd0, 1'b1, 8'd54});
        @(negedge clk); drive(0, 0, 1, 8'd0); #1;
        check("R1 counts cleared, no NACK", {31'd0, nack_valid}, 32'd0);
        // R4: third request from source 1 after reset is refused
        @(negedge clk); drive(1, 0, 1, 8'd56);
        @(negedge clk); drive(0, 0, 1, 8'd0); #1;
        check("R4 NACK to source 1", {29'd0, nack_valid, nack_dst}, {29'd0, 1'b1, 2'd1});

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule